// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Threshold Interrupts

This block sits between a processor and a serial audio engine. It holds two queues of 32-bit sample words. The playback queue is filled through a small word-addressed register port and drained by the serial engine. The capture queue is filled by the serial engine and drained through the register port. The serial side uses a single-cycle strobe per word: `tx_pop` takes a word and `rx_push` delivers one.

Software sets a 7-bit trigger level for the playback queue. It can read how many playback entries are free and how many capture words are waiting, and it can hold either queue empty with a flush bit. Three sticky status flags are raised from level comparisons and events:
- capture data available,
- playback room at or above the trigger,
- playback underrun.

Writing a 1 to a status bit clears that bit. Each flag has its own enable, and the enabled flags are ORed into one registered interrupt line. Two 32-bit counters track the words that cross the serial side, one per direction. Software can load either counter, and writing zero resets it.

Register word addresses on `reg_addr`:
- 0: control
- 1: status
- 2: interrupt enable
- 3: levels
- 4: playback data (write)
- 5: capture data (read)
- 6: playback counter
- 7: capture counter

Top module: `audio_sample_fifo`

## Requirements
- R1: Synchronous reset sets the following. Control reads 0x0000_4000, which is a trigger of 0x40 with all enables and flushes off. The enable register, the counters, `irq`, `tx_data` and `reg_rdata` are all zero. Both queues are empty.
- R2: Words written to address 4 leave in write order on `tx_data`. A word is presented one cycle after a `tx_pop` seen while the control bit 0 (playback run) is set.
- R3: A write to a full queue is dropped. A pop from an empty queue returns zero and leaves the level unchanged. The playback queue holds 128 words and the capture queue holds 32.
- R4: Words pushed with `rx_push` are stored only while control bit 1 (capture run) is set. Reads of address 5 return the stored words in arrival order.
- R5: A read of any register returns its value on `reg_rdata` one cycle after the `reg_rd` strobe. In the levels register, bits [7:0] hold the free playback entries and bits [21:16] hold the capture words present.
- R6: While control bit 2 (playback flush) or bit 3 (capture flush) is set, the matching queue is held empty and writes into it are ignored.
- R7: Status bit 1 is set whenever the free playback entries are at or above the trigger, which is control bits [14:8].
- R8: Status bit 0 is set whenever at least one capture word is present.
- R9: Status bit 2 is set by a `tx_pop` while playback runs and the playback queue is empty.
- R10: Writing 1 to a status bit clears it. Writing 0 keeps it. A condition that still holds sets the bit again on the same edge.
- R11: `irq` is high exactly when some status bit and its enable bit at address 2 (same bit positions) are both set. It is updated on the same edge as those registers.
- R12: Each counter adds one per word moved on its serial side. A write to address 6 or 7 loads the written value, and the load wins over a same-cycle increment.
- R13: While playback does not run, `tx_pop` neither removes a word, changes `tx_data`, nor sets underrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid one cycle after `reg_rd` |
| tx_pop | input | 1 | Serial engine takes a playback word |
| tx_data | output | 32 | Playback word, valid one cycle after `tx_pop` |
| rx_push | input | 1 | Serial engine delivers a capture word |
| rx_data | input | 32 | Capture word |
| irq | output | 1 | Interrupt request |

## Verification
Every result of this block lands one clock edge after its cause:
- `tx_data` follows `tx_pop` by one edge.
- `reg_rdata` follows `reg_rd` by one edge.
- A status flag follows the level it compares by one edge, and `irq` rises on that same edge.

The bench drives inputs on falling edges. A queue-based model advances on each rising edge, and outputs are compared with it on the next falling edge. Directed checks also read registers back at the falling edge after the read strobe. Where a flag depends on a level that changed in the previous cycle, they first wait one further cycle.

// File: rtl/asf_pkg.sv
package asf_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL  = 3'd0,
    RA_STAT  = 3'd1,
    RA_IEN   = 3'd2,
    RA_LVL   = 3'd3,
    RA_TXD   = 3'd4,
    RA_RXD   = 3'd5,
    RA_TXCNT = 3'd6,
    RA_RXCNT = 3'd7
  } reg_addr_e;

  // status / enable bit positions
  localparam int NSRC    = 3;
  localparam int SRC_RXA = 0;
  localparam int SRC_TXE = 1;
  localparam int SRC_TXU = 2;

  // control word layout
  localparam int CTL_TXEN     = 0;
  localparam int CTL_RXEN     = 1;
  localparam int CTL_TXFL     = 2;
  localparam int CTL_RXFL     = 3;
  localparam int CTL_TRIG_LSB = 8;
  localparam int TRIG_W       = 7;
  localparam logic [TRIG_W-1:0] TRIG_RST = 7'h40;

  // level word layout
  localparam int LVL_TX_LSB = 0;
  localparam int LVL_TX_W   = 8;
  localparam int LVL_RX_LSB = 16;
  localparam int LVL_RX_W   = 6;

  typedef struct packed {
    logic [TRIG_W-1:0] trig;
    logic              rx_flush;
    logic              tx_flush;
    logic              rx_en;
    logic              tx_en;
  } ctrl_t;
endpackage

// File: rtl/asf_fifo.sv
module asf_fifo #(
  parameter int W         = 32,
  parameter int DEPTH     = 128,
  parameter bit COUNT_POP = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     flush,
  input  logic                     push,
  input  logic [W-1:0]             push_data,
  input  logic                     pop,
  output logic [W-1:0]             pop_data,
  output logic [$clog2(DEPTH):0]   count,
  output logic                     moved
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign push_ok = push && !flush && (count != CW'(DEPTH));
  assign pop_ok  = pop && !flush && (count != '0);

  generate
    if (COUNT_POP) begin : g_cnt_pop
      assign moved = pop_ok;
    end else begin : g_cnt_push
      assign moved = push_ok;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst)      pop_data <= '0;
    else if (pop) pop_data <= pop_ok ? mem[rd_ptr] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + AW'(1);
      if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + AW'(1);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end
endmodule

// File: rtl/asf_irq.sv
module asf_irq #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic         en_wr,
  input  logic [N-1:0] en_wdata,
  output logic [N-1:0] status,
  output logic [N-1:0] enable,
  output logic         irq
);
  logic [N-1:0] status_d, enable_d;

  always_comb begin
    status_d = (status & ~clr) | set;
    enable_d = en_wr ? en_wdata : enable;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      enable <= '0;
      irq    <= 1'b0;
    end else begin
      status <= status_d;
      enable <= enable_d;
      irq    <= |(status_d & enable_d);
    end
  end
endmodule

// File: rtl/asf_word_ctr.sv
module asf_word_ctr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst)       value <= '0;
    else if (load) value <= load_val;
    else if (inc)  value <= value + W'(1);
  end
endmodule

// File: rtl/audio_sample_fifo.sv
module audio_sample_fifo
  import asf_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int TX_DEPTH = 128,
  parameter int RX_DEPTH = 32,
  parameter int CNT_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              tx_pop,
  output logic [DATA_W-1:0] tx_data,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_data,
  output logic              irq
);
  localparam int TX_CW = $clog2(TX_DEPTH) + 1;
  localparam int RX_CW = $clog2(RX_DEPTH) + 1;

  ctrl_t ctrl;
  logic  tx_run, rx_run, tx_fl, rx_fl;
  logic  wr_ctrl, wr_stat, wr_ien, wr_txd, wr_txcnt, wr_rxcnt, rd_rxd;

  assign tx_run = ctrl.tx_en;
  assign rx_run = ctrl.rx_en;
  assign tx_fl  = ctrl.tx_flush;
  assign rx_fl  = ctrl.rx_flush;

  assign wr_ctrl  = reg_wr && (reg_addr == RA_CTRL);
  assign wr_stat  = reg_wr && (reg_addr == RA_STAT);
  assign wr_ien   = reg_wr && (reg_addr == RA_IEN);
  assign wr_txd   = reg_wr && (reg_addr == RA_TXD);
  assign wr_txcnt = reg_wr && (reg_addr == RA_TXCNT);
  assign wr_rxcnt = reg_wr && (reg_addr == RA_RXCNT);
  assign rd_rxd   = reg_rd && (reg_addr == RA_RXD);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '{trig: TRIG_RST, default: 1'b0};
    end else if (wr_ctrl) begin
      ctrl <= '{trig:     reg_wdata[CTL_TRIG_LSB +: TRIG_W],
                rx_flush: reg_wdata[CTL_RXFL],
                tx_flush: reg_wdata[CTL_TXFL],
                rx_en:    reg_wdata[CTL_RXEN],
                tx_en:    reg_wdata[CTL_TXEN]};
    end
  end

  // queues
  logic [TX_CW-1:0]  tx_cnt;
  logic [RX_CW-1:0]  rx_cnt;
  logic [DATA_W-1:0] rx_rd_data;
  logic              tx_moved, rx_moved;

  asf_fifo #(.W(DATA_W), .DEPTH(TX_DEPTH), .COUNT_POP(1'b1)) u_txq (
    .clk(clk), .rst(rst), .flush(tx_fl),
    .push(wr_txd), .push_data(reg_wdata[DATA_W-1:0]),
    .pop(tx_pop && tx_run), .pop_data(tx_data),
    .count(tx_cnt), .moved(tx_moved)
  );

  asf_fifo #(.W(DATA_W), .DEPTH(RX_DEPTH), .COUNT_POP(1'b0)) u_rxq (
    .clk(clk), .rst(rst), .flush(rx_fl),
    .push(rx_push && rx_run), .push_data(rx_data),
    .pop(rd_rxd), .pop_data(rx_rd_data),
    .count(rx_cnt), .moved(rx_moved)
  );

  // status and interrupt
  logic [TX_CW-1:0] tx_free;
  logic [NSRC-1:0]  src_set, src_clr, status, enable;

  assign tx_free = TX_CW'(TX_DEPTH) - tx_cnt;

  always_comb begin
    src_set          = '0;
    src_set[SRC_RXA] = (rx_cnt != '0);
    src_set[SRC_TXE] = (32'(tx_free) >= 32'(ctrl.trig));
    src_set[SRC_TXU] = tx_pop && tx_run && (tx_cnt == '0);
    src_clr          = wr_stat ? reg_wdata[NSRC-1:0] : '0;
  end

  asf_irq #(.N(NSRC)) u_irq (
    .clk(clk), .rst(rst), .set(src_set), .clr(src_clr),
    .en_wr(wr_ien), .en_wdata(reg_wdata[NSRC-1:0]),
    .status(status), .enable(enable), .irq(irq)
  );

  // serial-side word counters
  logic [CNT_W-1:0] tx_smp, rx_smp;

  asf_word_ctr #(.W(CNT_W)) u_txctr (
    .clk(clk), .rst(rst), .load(wr_txcnt),
    .load_val(reg_wdata[CNT_W-1:0]), .inc(tx_moved), .value(tx_smp)
  );

  asf_word_ctr #(.W(CNT_W)) u_rxctr (
    .clk(clk), .rst(rst), .load(wr_rxcnt),
    .load_val(reg_wdata[CNT_W-1:0]), .inc(rx_moved), .value(rx_smp)
  );

  // read path
  logic [REG_W-1:0] rd_val, rdata_q, lvl;
  logic             rd_from_q;

  always_comb begin
    lvl = '0;
    lvl[LVL_TX_LSB +: LVL_TX_W] = LVL_TX_W'(tx_free);
    lvl[LVL_RX_LSB +: LVL_RX_W] = LVL_RX_W'(rx_cnt);
    rd_val = '0;
    case (reg_addr)
      RA_CTRL: begin
        rd_val[CTL_TXEN] = ctrl.tx_en;
        rd_val[CTL_RXEN] = ctrl.rx_en;
        rd_val[CTL_TXFL] = ctrl.tx_flush;
        rd_val[CTL_RXFL] = ctrl.rx_flush;
        rd_val[CTL_TRIG_LSB +: TRIG_W] = ctrl.trig;
      end
      RA_STAT:  rd_val = REG_W'(status);
      RA_IEN:   rd_val = REG_W'(enable);
      RA_LVL:   rd_val = lvl;
      RA_TXCNT: rd_val = REG_W'(tx_smp);
      RA_RXCNT: rd_val = REG_W'(rx_smp);
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q   <= '0;
      rd_from_q <= 1'b0;
    end else if (reg_rd) begin
      rdata_q   <= rd_val;
      rd_from_q <= (reg_addr == RA_RXD);
    end
  end

  assign reg_rdata = rd_from_q ? REG_W'(rx_rd_data) : rdata_q;
endmodule

// File: rtl/asf_chk.sv
module asf_chk
  import asf_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int TX_DEPTH = 128,
  parameter int RX_DEPTH = 32,
  parameter int CNT_W    = 32
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      tx_pop,
  input logic                      tx_run,
  input logic                      tx_fl,
  input logic                      tx_ld,
  input logic [$clog2(TX_DEPTH):0] tx_cnt,
  input logic [$clog2(RX_DEPTH):0] rx_cnt,
  input logic [DATA_W-1:0]         tx_data,
  input logic [NSRC-1:0]           status,
  input logic [NSRC-1:0]           enable,
  input logic                      irq,
  input logic [CNT_W-1:0]          tx_smp
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (32'(tx_cnt) <= TX_DEPTH) && (32'(rx_cnt) <= RX_DEPTH)); // R3
  AST_EMPTY_POP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (tx_pop && tx_run && tx_cnt == '0) |=> (tx_data == '0)); // R3
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    tx_fl |=> (tx_cnt == '0)); // R6
  AST_UNDERRUN_FLAG: assert property (@(posedge clk) disable iff (rst)
    (tx_pop && tx_run && tx_cnt == '0) |=> status[SRC_TXU]); // R9
  AST_IRQ_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    irq |-> ((status & enable) != '0)); // R11
  AST_CTR_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!(tx_pop && tx_run) && !tx_ld) |=> $stable(tx_smp)); // R12
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !tx_run |=> $stable(tx_data)); // R13
endmodule

bind audio_sample_fifo asf_chk #(
  .DATA_W(DATA_W), .TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .tx_pop(tx_pop), .tx_run(tx_run), .tx_fl(tx_fl),
  .tx_ld(wr_txcnt), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .tx_data(tx_data),
  .status(status), .enable(enable), .irq(irq), .tx_smp(tx_smp)
);

// File: tb/tb_audio_sample_fifo.sv
`timescale 1ns/1ps
module tb_audio_sample_fifo;
  localparam int TXD = 128;
  localparam int RXD = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        w = 1'b0, r = 1'b0, pop = 1'b0, push = 1'b0;
  logic [2:0]  a = '0;
  logic [31:0] wd = '0, rxd = '0;
  logic [31:0] reg_rdata, tx_data;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  audio_sample_fifo dut (
    .clk(clk), .rst(rst), .reg_wr(w), .reg_rd(r), .reg_addr(a),
    .reg_wdata(wd), .reg_rdata(reg_rdata), .tx_pop(pop), .tx_data(tx_data),
    .rx_push(push), .rx_data(rxd), .irq(irq)
  );

  // behavioural reference
  logic [31:0] txq[$];
  logic [31:0] rxq[$];
  logic [31:0] m_ctrl, m_rd, m_txd, m_txs, m_rxs;
  logic [2:0]  m_st, m_en;
  logic        m_irq;

  always @(posedge clk) begin
    int n_tx, n_rx, trig;
    logic ten, ren, tfl, rfl;
    logic [2:0] setv, clrv;
    if (rst) begin
      txq.delete(); rxq.delete();
      m_ctrl = 32'h4000; m_rd = 0; m_txd = 0; m_txs = 0; m_rxs = 0;
      m_st = 0; m_en = 0; m_irq = 0;
    end else begin
      n_tx = txq.size(); n_rx = rxq.size();
      ten = m_ctrl[0]; ren = m_ctrl[1]; tfl = m_ctrl[2]; rfl = m_ctrl[3];
      trig = int'(m_ctrl[14:8]);
      setv[0] = (n_rx > 0);
      setv[1] = ((TXD - n_tx) >= trig);
      setv[2] = pop && ten && (n_tx == 0);
      if (r) begin
        case (a)
          3'd0: m_rd = m_ctrl;
          3'd1: m_rd = {29'd0, m_st};
          3'd2: m_rd = {29'd0, m_en};
          3'd3: m_rd = (n_rx << 16) | (TXD - n_tx);
          3'd5: m_rd = (!rfl && n_rx > 0) ? rxq.pop_front() : 32'd0;
          3'd6: m_rd = m_txs;
          3'd7: m_rd = m_rxs;
          default: m_rd = 0;
        endcase
      end
      if (pop && ten) begin
        if (!tfl && n_tx > 0) begin m_txd = txq.pop_front(); m_txs = m_txs + 1; end
        else m_txd = 0;
      end
      if (push && ren && !rfl && n_rx < RXD) begin rxq.push_back(rxd); m_rxs = m_rxs + 1; end
      clrv = 0;
      if (w) begin
        case (a)
          3'd0: m_ctrl = wd & 32'h7F0F;
          3'd1: clrv = wd[2:0];
          3'd2: m_en = wd[2:0];
          3'd4: if (!tfl && n_tx < TXD) txq.push_back(wd);
          3'd6: m_txs = wd;
          3'd7: m_rxs = wd;
          default: ;
        endcase
      end
      if (tfl) txq.delete();
      if (rfl) rxq.delete();
      m_st  = (m_st & ~clrv) | setv;
      m_irq = |(m_st & m_en);
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 tx_data", tx_data, m_txd);
      chk("R5 reg_rdata", reg_rdata, m_rd);
      chk("R11 irq", {31'd0, irq}, {31'd0, m_irq});
    end
  end

  task automatic wreg(input logic [2:0] ad, input logic [31:0] d);
    w = 1'b1; a = ad; wd = d;
    @(negedge clk);
    w = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] ad, output logic [31:0] v);
    r = 1'b1; a = ad;
    @(negedge clk);
    r = 1'b0;
    v = reg_rdata;
  endtask

  task automatic spop();
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
  endtask

  task automatic spush(input logic [31:0] d);
    push = 1'b1; rxd = d;
    @(negedge clk);
    push = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 tx_data", tx_data, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 rdata", reg_rdata, 0);
    rreg(3'd0, v); chk("R1 ctrl", v, 32'h4000);
    rreg(3'd3, v); chk("R1 levels", v, 32'h80);
    rreg(3'd2, v); chk("R1 enable", v, 0);
    rreg(3'd6, v); chk("R1 txcnt", v, 0);
    rreg(3'd1, v); chk("R7 tx room at reset", v, 32'h2);

    wreg(3'd0, 32'h4003);
    for (int i = 0; i < 5; i++) wreg(3'd4, 32'hA000_0000 + i);
    rreg(3'd3, v); chk("R5 levels after 5", v, 32'h7B);
    for (int i = 0; i < 5; i++) begin
      spop(); chk("R2 order", tx_data, 32'hA000_0000 + i);
    end
    spop(); chk("R3 empty pop zero", tx_data, 0);
    rreg(3'd1, v); chk("R9 underrun", v, 32'h6);
    rreg(3'd6, v); chk("R12 tx words", v, 5);

    wreg(3'd1, 32'h4); rreg(3'd1, v); chk("R10 w1c", v, 32'h2);
    wreg(3'd1, 32'h2); rreg(3'd1, v); chk("R10 reassert", v, 32'h2);

    wreg(3'd0, 32'h7F03);
    wreg(3'd4, 32'hB000_0000); wreg(3'd4, 32'hB000_0001);
    wreg(3'd1, 32'h2); rreg(3'd1, v); chk("R7 below trigger", v, 0);
    spop(); spop();
    rreg(3'd1, v); chk("R7 at trigger", v, 32'h2);

    wreg(3'd2, 32'h1);
    chk("R11 masked", {31'd0, irq}, 0);
    spush(32'h1234_5678);
    @(negedge clk);
    chk("R8 irq", {31'd0, irq}, 1);
    rreg(3'd1, v); chk("R8 status", v, 32'h3);
    rreg(3'd5, v); chk("R4 rx word", v, 32'h1234_5678);
    rreg(3'd5, v); chk("R3 rx empty zero", v, 0);
    wreg(3'd1, 32'h1);
    @(negedge clk);
    chk("R10 irq cleared", {31'd0, irq}, 0);

    for (int i = 0; i < 34; i++) spush(32'h0C00_0000 + i);
    rreg(3'd3, v); chk("R3 rx full", v, 32'h0020_0080);
    rreg(3'd7, v); chk("R12 rx words", v, 33);
    wreg(3'd7, 0); rreg(3'd7, v); chk("R12 reset", v, 0);
    rreg(3'd5, v); chk("R4 rx first", v, 32'h0C00_0000);

    wreg(3'd0, 32'h7F0B);
    spush(32'h55);
    rreg(3'd3, v); chk("R6 flushed", v, 32'h80);
    wreg(3'd0, 32'h7F03);
    rreg(3'd3, v); chk("R6 after flush", v, 32'h80);
    rreg(3'd5, v); chk("R6 nothing kept", v, 0);

    wreg(3'd0, 32'h7F02);
    wreg(3'd1, 32'h7);
    wreg(3'd4, 32'h0000_C0DE);
    spop(); chk("R13 tx held", tx_data, 32'hB000_0001);
    rreg(3'd3, v); chk("R13 level", v, 32'h7F);
    rreg(3'd1, v); chk("R13 no underrun", v, 32'h2);

    wreg(3'd0, 32'h7F00);
    spush(32'h77);
    rreg(3'd3, v); chk("R4 rx stopped", v, 32'h7F);

    wreg(3'd0, 32'h4001);
    for (int i = 0; i < 130; i++) wreg(3'd4, 32'hD000_0000 + i);
    rreg(3'd3, v); chk("R3 tx full", v, 0);
    spop(); chk("R2 first kept", tx_data, 32'h0000_C0DE);
    rreg(3'd6, v); chk("R12 tx total", v, 8);
    rreg(3'd0, v); chk("R1 ctrl readback", v, 32'h4001);

    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule